// File: doc/BRIEF.md
# Multi-Channel Indirect Register Access Controller

This block is the processor-facing register decoder of a multi-channel line framer. Each channel owns a 16-location direct address window. Inside that window, five register groups are reached only through a pair of registers. The even offset of the pair holds an entry index, and the odd offset is a data port into the group's backing storage. Software first writes the entry index into the index register. It then reads or writes the data port. After every data-port access the index advances by one, so a run of consecutive entries can be streamed with one index write followed by repeated data accesses.

Each channel/group pair keeps its own 8-bit index pointer and its own `DEPTH`-entry storage. An entry is selected by the pointer modulo `DEPTH`, while the pointer itself wraps modulo 256. Read data is registered and appears on `rdata_o` in the cycle after the read strobe.

Top module: `irac_top`

## Requirements
- R1: The byte address splits into channel = `addr_i[7:4]` and offset = `addr_i[3:0]`. Offsets 0/1, 2/3, 4/5, 8/9 and A/B form groups 0 to 4, in that order. In each pair the even offset is the index register and the odd offset is the data port.
- R2: A write to an index register loads `wdata_i` into that group's pointer. A read of the index register returns the current pointer and has no side effect.
- R3: A data-port write stores `wdata_i` at entry (pointer mod `DEPTH`) and then adds one to the pointer.
- R4: A data-port read returns the entry at (pointer mod `DEPTH`) and then adds one to the pointer.
- R5: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R6: An access to one channel/group changes no other group's pointer or storage.
- R7: Offsets 6, 7 and C to F, and channels at or above `NUM_CH`, read as zero, and writes to them change nothing.
- R8: Reset clears every pointer, every storage entry and `rdata_o`.
- R9: `rdata_o` carries the read value in the cycle after `rd_en_i`. It is zero in any cycle that follows no read.
- R10: When `wr_en_i` and `rd_en_i` are both high, only the write is performed, and the following `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Channel nibble and register offset |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A pointer that skips or fails to advance shows up on the next data-port access of that group, because the wrong entry is read back one cycle after the strobe. A stray update to a neighbouring group stays hidden until that group's index register or data port is read. For that reason, the bench ends by reading back every index register of every channel and compares each value with its model. An aliasing error in the modulo-`DEPTH` entry selection appears as soon as a stream longer than `DEPTH` entries is read back.

// File: rtl/irac_pkg.sv
package irac_pkg;
  localparam int NUM_GRP = 5;

  typedef struct packed {
    logic       valid;
    logic       is_data;
    logic [2:0] grp;
  } off_dec_t;

  function automatic off_dec_t decode_off(input logic [3:0] off);
    off_dec_t d;
    d.valid   = 1'b1;
    d.is_data = off[0];
    unique case (off[3:1])
      3'd0: d.grp = 3'd0;
      3'd1: d.grp = 3'd1;
      3'd2: d.grp = 3'd2;
      3'd4: d.grp = 3'd3;
      3'd5: d.grp = 3'd4;
      default: begin
        d.grp   = 3'd0;
        d.valid = 1'b0;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/irac_decode.sv
module irac_decode
  import irac_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int N     = NUM_CH * NUM_GRP,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [7:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic [N-1:0]     idx_we_o,
  output logic [N-1:0]     dat_we_o,
  output logic [N-1:0]     dat_re_o,
  output logic             hit_o,
  output logic             is_data_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [4:0] NUM_CH_L = 5'(NUM_CH);

  off_dec_t d;
  logic     ch_ok;
  logic     wr, rd;
  int       sel_int;

  always_comb begin
    d       = decode_off(addr_i[3:0]);
    ch_ok   = {1'b0, addr_i[7:4]} < NUM_CH_L;
    hit_o   = d.valid && ch_ok;
    is_data_o = d.is_data;
    sel_int = int'(addr_i[7:4]) * NUM_GRP + int'(d.grp);
    sel_o   = hit_o ? SEL_W'(sel_int) : '0;
    wr      = wr_en_i;
    rd      = rd_en_i && !wr_en_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_strb
    logic me;
    assign me          = hit_o && (sel_int == k);
    assign idx_we_o[k] = me && wr && !d.is_data;
    assign dat_we_o[k] = me && wr && d.is_data;
    assign dat_re_o[k] = me && rd && d.is_data;
  end
endmodule

// File: rtl/irac_bank.sv
module irac_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              dat_we_i,
  input  logic              dat_re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] entry_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx     = ptr_q[IDX_W-1:0];
  assign ptr_o   = ptr_q;
  assign entry_o = mem_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (idx_we_i) begin
      ptr_q <= PTR_W'(wdata_i);
    end else if (dat_we_i || dat_re_i) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[e] <= '0;
      else if (dat_we_i && idx == IDX_W'(e))    mem_q[e] <= wdata_i;
    end
  end
endmodule

// File: rtl/irac_rdmux.sv
module irac_rdmux #(
  parameter int N      = 40,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N*PTR_W-1:0]  ptr_i,
  input  logic [N*DATA_W-1:0] entry_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                hit_i,
  input  logic                is_data_i,
  output logic [DATA_W-1:0]   val_o
);
  logic [PTR_W-1:0]  p;
  logic [DATA_W-1:0] e;

  always_comb begin
    p = '0;
    e = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) begin
        p = ptr_i[k*PTR_W +: PTR_W];
        e = entry_i[k*DATA_W +: DATA_W];
      end
    end
    if (!hit_i)         val_o = '0;
    else if (is_data_i) val_o = e;
    else                val_o = DATA_W'(p);
  end
endmodule

// File: rtl/irac_top.sv
module irac_top
  import irac_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 16,
  localparam int DATA_W = 8,
  localparam int PTR_W  = 8,
  localparam int N      = NUM_CH * NUM_GRP,
  localparam int SEL_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0]        idx_we, dat_we, dat_re;
  logic                hit, is_data;
  logic [SEL_W-1:0]    sel;
  logic [N*PTR_W-1:0]  ptr_flat;
  logic [N*DATA_W-1:0] entry_flat;
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_q;

  irac_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .idx_we_o (idx_we),
    .dat_we_o (dat_we),
    .dat_re_o (dat_re),
    .hit_o    (hit),
    .is_data_o(is_data),
    .sel_o    (sel)
  );

  for (genvar k = 0; k < N; k++) begin : g_bank
    irac_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .idx_we_i(idx_we[k]),
      .dat_we_i(dat_we[k]),
      .dat_re_i(dat_re[k]),
      .wdata_i (wdata_i),
      .ptr_o   (ptr_flat[k*PTR_W +: PTR_W]),
      .entry_o (entry_flat[k*DATA_W +: DATA_W])
    );
  end

  irac_rdmux #(.N(N), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mux (
    .ptr_i    (ptr_flat),
    .entry_i  (entry_flat),
    .sel_i    (sel),
    .hit_i    (hit),
    .is_data_i(is_data),
    .val_o    (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdata_q <= '0;
    else if (rd_en_i && !wr_en_i)    rdata_q <= rd_val;
    else                             rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irac_chk.sv
module irac_chk #(
  parameter int N = 40
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [7:0]     addr_i,
  input logic           wr_en_i,
  input logic           rd_en_i,
  input logic [7:0]     wdata_i,
  input logic [7:0]     rdata_o,
  input logic [N-1:0]   idx_we,
  input logic [N-1:0]   dat_we,
  input logic [N-1:0]   dat_re,
  input logic [N*8-1:0] ptr_flat
);
  logic rsvd_off;
  assign rsvd_off = (addr_i[3:0] == 4'h6) || (addr_i[3:0] == 4'h7) || (addr_i[3:2] == 2'b11);

  // R7
  rsvd_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && rsvd_off) |=> (rdata_o == 8'h00));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> (rdata_o == 8'h00));

  // R6
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idx_we, dat_we, dat_re}));

  for (genvar k = 0; k < N; k++) begin : g_p
    // R2
    idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_we[k] |=> (ptr_flat[k*8 +: 8] == $past(wdata_i)));
    // R5
    ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dat_we[k] || dat_re[k]) |=> (ptr_flat[k*8 +: 8] == $past(ptr_flat[k*8 +: 8]) + 8'd1));
    // R6
    ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(idx_we[k] || dat_we[k] || dat_re[k]) |=> $stable(ptr_flat[k*8 +: 8]));
  end
endmodule

bind irac_top irac_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .idx_we  (idx_we),
  .dat_we  (dat_we),
  .dat_re  (dat_re),
  .ptr_flat(ptr_flat)
);

// File: tb/irac_top_tb.sv
module irac_top_tb_top;
  localparam int NCH = 8;
  localparam int DEP = 16;
  localparam int NG  = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] ptr_m [NCH][NG];
  logic [7:0] mem_m [NCH][NG][DEP];

  always #2 clk_i = ~clk_i;

  irac_top #(.NUM_CH(NCH), .DEPTH(DEP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  // R1 group offset map
  function automatic logic [3:0] off_of(input int g);
    return (g < 3) ? 4'(2 * g) : 4'(2 * g + 2);
  endfunction

  function automatic logic [7:0] a_idx(input int ch, input int g);
    return {4'(ch), off_of(g)};
  endfunction

  function automatic logic [7:0] a_dat(input int ch, input int g);
    return {4'(ch), off_of(g) | 4'h1};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(rdata_o, exp, req);
  endtask

  task automatic m_idx_wr(input int ch, input int g, input logic [7:0] v);
    wr(a_idx(ch, g), v);
    ptr_m[ch][g] = v;
  endtask

  task automatic m_dat_wr(input int ch, input int g, input logic [7:0] v);
    wr(a_dat(ch, g), v);
    mem_m[ch][g][ptr_m[ch][g] % DEP] = v;
    ptr_m[ch][g] = ptr_m[ch][g] + 8'd1;
  endtask

  task automatic m_dat_rd(input int ch, input int g, input string req);
    rd(a_dat(ch, g), mem_m[ch][g][ptr_m[ch][g] % DEP], req);
    ptr_m[ch][g] = ptr_m[ch][g] + 8'd1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) begin
        ptr_m[c][g] = '0;
        for (int e = 0; e < DEP; e++) mem_m[c][g][e] = '0;
      end
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check(rdata_o, 8'h00, "R8 rdata");
    rst_ni = 1'b1;
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) rd(a_idx(c, g), 8'h00, "R8 ptr");
    for (int g = 0; g < NG; g++) m_dat_rd(3, g, "R8 entry");

    // R1 R2: distinct pointer per channel/group, read back
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) m_idx_wr(c, g, 8'((c * 16 + g * 3 + 1) ^ 8'h5A));
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) rd(a_idx(c, g), ptr_m[c][g], "R1 R2 idx");

    // R3 R4: stream longer than DEPTH, then read back
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) begin
        m_idx_wr(c, g, 8'h00);
        for (int i = 0; i < DEP + 4; i++) m_dat_wr(c, g, 8'(c * 37 + g * 11 + i * 5 + 1));
        rd(a_idx(c, g), ptr_m[c][g], "R3 ptr advance");
      end
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) begin
        m_idx_wr(c, g, 8'h02);
        for (int i = 0; i < DEP; i++) m_dat_rd(c, g, "R4 stream read");
        rd(a_idx(c, g), ptr_m[c][g], "R4 ptr advance");
      end

    // R5 wrap
    m_idx_wr(5, 0, 8'hFE);
    m_dat_wr(5, 0, 8'hA1);
    m_dat_wr(5, 0, 8'hA2);
    m_dat_wr(5, 0, 8'hA3);
    rd(a_idx(5, 0), 8'h01, "R5 wrap");
    m_idx_wr(5, 0, 8'hFF);
    m_dat_rd(5, 0, "R5 entry before wrap");
    rd(a_idx(5, 0), 8'h00, "R5 wrap on read");
    m_idx_wr(5, 0, 8'h07);
    m_dat_wr(5, 0, 8'h0D);
    rd(a_idx(5, 0), 8'h08, "R3 example");

    // R7 reserved offsets and absent channels
    for (int c = 0; c < 16; c++)
      for (int o = 0; o < 16; o++) begin
        if (c >= NCH || o == 6 || o == 7 || o >= 12) begin
          wr({4'(c), 4'(o)}, 8'hC3);
          rd({4'(c), 4'(o)}, 8'h00, "R7 reserved");
        end
      end

    // R10 both strobes: write wins, rdata zero
    @(negedge clk_i);
    addr_i = a_idx(2, 4); wdata_i = 8'h77; wr_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    ptr_m[2][4] = 8'h77;
    check(rdata_o, 8'h00, "R10 rdata");
    rd(a_idx(2, 4), 8'h77, "R10 write done");

    // R9 idle cycle after read
    rd(a_idx(2, 4), 8'h77, "R9 read");
    @(negedge clk_i);
    check(rdata_o, 8'h00, "R9 idle");

    // R6 final sweep over every pointer and entry
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) rd(a_idx(c, g), ptr_m[c][g], "R6 ptr");
    for (int c = 0; c < NCH; c++)
      for (int g = 0; g < NG; g++) begin
        m_idx_wr(c, g, 8'h00);
        for (int i = 0; i < DEP; i++) m_dat_rd(c, g, "R6 entry");
      end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule